// File: doc/BRIEF.md
# Token-Stream Configuration Register Agent

This block is a slave that answers configuration requests arriving as a stream of tokens. Each token is an 8-bit value plus a flag that marks it as a control token or a plain data byte. The agent parses each request, reads or writes one of two internal 32-bit register banks, and sends back a reply on a second token stream. Both streams use a valid/ready handshake. A token moves when valid and ready are high at the same rising clock edge.

A request starts with an opcode control token. Control 192 writes the main bank, 193 reads the main bank, and 36 writes the auxiliary bank. Three return-identifier data bytes follow and are discarded. Then come two address bytes, most significant first. A write then carries four data bytes, most significant first. The request ends with control token 1.

Replies have three forms:
- A successful write gets control 3 then control 1.
- A successful read gets control 3, the four register bytes (most significant first), then control 1.
- Any failure gets control 4 then control 1.

A `lock` input models a security mode: while it is high, every write fails. Reads still succeed. The auxiliary bank drives the `aux_regs` output so that hardware can use its contents.

The parser has seven states:
- `ST_OPC` waits for the opcode.
- `ST_RID` counts the return-identifier bytes.
- `ST_ADR` collects the address.
- `ST_DAT` collects the write data.
- `ST_END` expects the closing token.
- `ST_DRAIN` throws away tokens until a closing token arrives.
- `ST_REPLY` holds the input stream while the reply is sent.

Transitions:
- opcode-known goes `ST_OPC`→`ST_RID`. Opcode-unknown goes →`ST_DRAIN`. A bare closing token goes →`ST_REPLY`.
- rid-done goes `ST_RID`→`ST_ADR`.
- adr-done goes `ST_ADR`→`ST_DAT` for writes, or →`ST_END` for reads.
- dat-done goes `ST_DAT`→`ST_END`.
- early-end goes from any field state →`ST_REPLY` with a failure.
- early-ctrl goes from any field state →`ST_DRAIN`.
- closed goes `ST_END`→`ST_REPLY`. Overlong goes `ST_END`→`ST_DRAIN`.
- drained goes `ST_DRAIN`→`ST_REPLY`.
- sent goes `ST_REPLY`→`ST_OPC`.

Top module: `cfg_tok_agent`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, and every register in both banks reads as 0.
- R2: A request with opcode control 192, a mapped main address (below NREG_MAIN) and `lock` low stores the four data bytes, assembled most-significant first, into that register. It is answered with control 3 then control 1. Control tokens emitted are only ever 1, 3 or 4.
- R3: A request with opcode control 193 and a mapped main address is answered with control 3, then four data tokens carrying the register from bit 31 down to bit 0, then control 1. This holds whatever `lock` is.
- R4: A request with opcode control 36 and an auxiliary address below NREG_AUX, with `lock` low, stores the word. It is answered with control 3 then control 1. Register k appears on `aux_regs[32k+31:32k]` from the cycle after the closing token.
- R5: With `lock` high when the closing token is accepted, a write to either bank is answered with control 4 then control 1, and no register changes.
- R6: An address at or above the bank size (all 16 address bits compared) is answered with control 4 then control 1 and changes nothing.
- R7: A first token that is not one of the three opcodes (a data token, or any other control value except 1) makes the agent discard tokens up to the next control 1. It then answers control 4 then control 1.
- R8: Two malformed requests are answered with control 4 then control 1 and change nothing:
  - a control 1 that arrives before all fields are received;
  - a data token where the closing token is due, in which case tokens are discarded up to the next control 1.
- R9: `in_ready` is 0 from the cycle after the closing token is accepted until the final reply token has been accepted. `out_valid` is never 1 while `in_ready` is 1. A reply token offered while `out_ready` is low stays valid and unchanged until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lock | input | 1 | Security mode: writes fail while high |
| in_valid | input | 1 | Request token valid |
| in_ready | output | 1 | Agent accepts a request token |
| in_ctrl | input | 1 | Request token is a control token |
| in_data | input | 8 | Request token value |
| out_valid | output | 1 | Reply token valid |
| out_ready | input | 1 | Receiver accepts a reply token |
| out_ctrl | output | 1 | Reply token is a control token |
| out_data | output | 8 | Reply token value |
| aux_regs | output | NREG_AUX*32 | Auxiliary bank contents, register k at bits 32k+31:32k |

## Verification
The bound checker watches the handshake on every cycle:
- a stalled reply token stays unchanged;
- the input and output streams never run at once;
- reply control tokens only take the values 1, 3 and 4;
- a failure header is always followed by the closing token;
- the auxiliary bank never moves while `lock` is high.

Only the bench's scenarios can show the rest. That covers whether a given request gets the correct reply and data bytes, and whether the main bank really holds what was written. It also covers the malformed cases: truncated, overlong and unknown-opcode requests are recognised at the right token. All of these are checked against a bench model under random backpressure.

// File: rtl/cfg_tok_pkg.sv
package cfg_tok_pkg;

    localparam logic [7:0] TK_END      = 8'd1;
    localparam logic [7:0] TK_ACK      = 8'd3;
    localparam logic [7:0] TK_NAK      = 8'd4;
    localparam logic [7:0] OP_WR_MAIN  = 8'd192;
    localparam logic [7:0] OP_RD_MAIN  = 8'd193;
    localparam logic [7:0] OP_WR_AUX   = 8'd36;

    localparam int RID_BYTES = 3;
    localparam int ADR_BYTES = 2;
    localparam int DAT_BYTES = 4;
    localparam int WORD_W    = 8 * DAT_BYTES;
    localparam int ADR_W     = 8 * ADR_BYTES;

    typedef enum logic [2:0] {
        ST_OPC,
        ST_RID,
        ST_ADR,
        ST_DAT,
        ST_END,
        ST_DRAIN,
        ST_REPLY
    } agent_st_t;

    typedef enum logic [1:0] {
        REQ_WR_MAIN,
        REQ_RD_MAIN,
        REQ_WR_AUX
    } req_kind_t;

    typedef enum logic [1:0] {
        RPL_ACK,
        RPL_NAK,
        RPL_DATA
    } rpl_kind_t;

endpackage

// File: rtl/cfg_tok_bank.sv
module cfg_tok_bank #(
    parameter int DEPTH  = 8,
    parameter int WORD_W = 32,
    parameter int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [IDX_W-1:0]        widx,
    input  logic [WORD_W-1:0]       wdata,
    output logic [DEPTH*WORD_W-1:0] flat
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_reg
        logic [WORD_W-1:0] r;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                r <= '0;
            end else if (we && (int'(widx) == g)) begin
                r <= wdata;
            end
        end

        assign flat[g*WORD_W +: WORD_W] = r;
    end

endmodule

// File: rtl/cfg_tok_reply.sv
module cfg_tok_reply
    import cfg_tok_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  rpl_kind_t         kind,
    input  logic [WORD_W-1:0] word,
    input  logic              out_ready,
    output logic              out_valid,
    output logic              out_ctrl,
    output logic [7:0]        out_data,
    output logic              done
);

    localparam logic [2:0] LEN_SHORT = 3'd2;
    localparam logic [2:0] LEN_LONG  = 3'(DAT_BYTES + 2);

    logic              busy_q;
    rpl_kind_t         kind_q;
    logic [2:0]        idx_q;
    logic [WORD_W-1:0] sh_q;
    logic [2:0]        len;
    logic              last;
    logic              fire;

    assign len  = (kind_q == RPL_DATA) ? LEN_LONG : LEN_SHORT;
    assign last = (idx_q == len - 3'd1);
    assign fire = busy_q && out_ready;
    assign done = fire && last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            kind_q <= RPL_ACK;
            idx_q  <= '0;
            sh_q   <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            kind_q <= kind;
            idx_q  <= '0;
            sh_q   <= word;
        end else if (fire) begin
            if (last) begin
                busy_q <= 1'b0;
                idx_q  <= '0;
            end else begin
                idx_q <= idx_q + 3'd1;
            end
            if (idx_q != 3'd0) begin
                sh_q <= {sh_q[WORD_W-9:0], 8'h00};
            end
        end
    end

    always_comb begin
        out_valid = busy_q;
        if (idx_q == 3'd0) begin
            out_ctrl = 1'b1;
            out_data = (kind_q == RPL_NAK) ? TK_NAK : TK_ACK;
        end else if (last) begin
            out_ctrl = 1'b1;
            out_data = TK_END;
        end else begin
            out_ctrl = 1'b0;
            out_data = sh_q[WORD_W-1 -: 8];
        end
    end

endmodule

// File: rtl/cfg_tok_agent.sv
module cfg_tok_agent
    import cfg_tok_pkg::*;
#(
    parameter int NREG_MAIN = 8,
    parameter int NREG_AUX  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       lock,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic                       in_ctrl,
    input  logic [7:0]                 in_data,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic                       out_ctrl,
    output logic [7:0]                 out_data,
    output logic [NREG_AUX*WORD_W-1:0] aux_regs
);

    localparam int MAIN_IW = (NREG_MAIN > 1) ? $clog2(NREG_MAIN) : 1;
    localparam int AUX_IW  = (NREG_AUX  > 1) ? $clog2(NREG_AUX)  : 1;
    localparam logic [ADR_W-1:0] MAIN_LIM = ADR_W'(NREG_MAIN);
    localparam logic [ADR_W-1:0] AUX_LIM  = ADR_W'(NREG_AUX);
    localparam logic [2:0] RID_LAST = 3'(RID_BYTES - 1);
    localparam logic [2:0] ADR_LAST = 3'(ADR_BYTES - 1);
    localparam logic [2:0] DAT_LAST = 3'(DAT_BYTES - 1);

    agent_st_t         state_q, state_d;
    req_kind_t         kind_q, kind_d;
    logic [2:0]        cnt_q, cnt_d;
    logic [ADR_W-1:0]  addr_q, addr_d;
    logic [WORD_W-1:0] wdata_q, wdata_d;

    logic                        fire, is_end, ok;
    logic                        main_hit, aux_hit;
    logic                        rpl_start, rpl_done;
    rpl_kind_t                   rpl_kind;
    logic                        commit_main, commit_aux;
    logic [NREG_MAIN*WORD_W-1:0] main_flat;
    logic [WORD_W-1:0]           rd_word;
    logic [MAIN_IW-1:0]          main_idx;

    assign fire     = in_valid && in_ready;
    assign is_end   = in_ctrl && (in_data == TK_END);
    assign main_hit = addr_q < MAIN_LIM;
    assign aux_hit  = addr_q < AUX_LIM;
    assign main_idx = addr_q[MAIN_IW-1:0];
    assign rd_word  = main_hit ? main_flat[int'(main_idx)*WORD_W +: WORD_W] : '0;

    always_comb begin
        unique case (kind_q)
            REQ_WR_MAIN: ok = main_hit && !lock;
            REQ_RD_MAIN: ok = main_hit;
            REQ_WR_AUX:  ok = aux_hit && !lock;
            default:     ok = 1'b0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OPC;
            kind_q  <= REQ_RD_MAIN;
            cnt_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
            cnt_q   <= cnt_d;
            addr_q  <= addr_d;
            wdata_q <= wdata_d;
        end
    end

    // next state and per-transition actions
    always_comb begin
        state_d     = state_q;
        kind_d      = kind_q;
        cnt_d       = cnt_q;
        addr_d      = addr_q;
        wdata_d     = wdata_q;
        rpl_start   = 1'b0;
        rpl_kind    = RPL_NAK;
        commit_main = 1'b0;
        commit_aux  = 1'b0;
        unique case (state_q)
            ST_OPC: begin
                if (fire) begin
                    cnt_d = '0;
                    if (in_ctrl && in_data == OP_WR_MAIN) begin
                        kind_d  = REQ_WR_MAIN;
                        state_d = ST_RID;
                    end else if (in_ctrl && in_data == OP_RD_MAIN) begin
                        kind_d  = REQ_RD_MAIN;
                        state_d = ST_RID;
                    end else if (in_ctrl && in_data == OP_WR_AUX) begin
                        kind_d  = REQ_WR_AUX;
                        state_d = ST_RID;
                    end else if (is_end) begin
                        rpl_start = 1'b1;
                        state_d   = ST_REPLY;
                    end else begin
                        state_d = ST_DRAIN;
                    end
                end
            end
            ST_RID, ST_ADR, ST_DAT: begin
                if (fire && in_ctrl) begin
                    if (is_end) begin
                        rpl_start = 1'b1;
                        state_d   = ST_REPLY;
                    end else begin
                        state_d = ST_DRAIN;
                    end
                end else if (fire) begin
                    cnt_d = cnt_q + 3'd1;
                    if (state_q == ST_RID) begin
                        if (cnt_q == RID_LAST) begin
                            cnt_d   = '0;
                            state_d = ST_ADR;
                        end
                    end else if (state_q == ST_ADR) begin
                        addr_d = {addr_q[ADR_W-9:0], in_data};
                        if (cnt_q == ADR_LAST) begin
                            cnt_d   = '0;
                            state_d = (kind_q == REQ_RD_MAIN) ? ST_END : ST_DAT;
                        end
                    end else begin
                        wdata_d = {wdata_q[WORD_W-9:0], in_data};
                        if (cnt_q == DAT_LAST) begin
                            cnt_d   = '0;
                            state_d = ST_END;
                        end
                    end
                end
            end
            ST_END: begin
                if (fire && is_end) begin
                    rpl_start = 1'b1;
                    state_d   = ST_REPLY;
                    if (ok) begin
                        rpl_kind    = (kind_q == REQ_RD_MAIN) ? RPL_DATA : RPL_ACK;
                        commit_main = (kind_q == REQ_WR_MAIN);
                        commit_aux  = (kind_q == REQ_WR_AUX);
                    end
                end else if (fire) begin
                    state_d = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (fire && is_end) begin
                    rpl_start = 1'b1;
                    state_d   = ST_REPLY;
                end
            end
            ST_REPLY: begin
                if (rpl_done) begin
                    state_d = ST_OPC;
                end
            end
            default: state_d = ST_OPC;
        endcase
    end

    // outputs
    always_comb begin
        in_ready = (state_q != ST_REPLY);
    end

    cfg_tok_bank #(.DEPTH(NREG_MAIN), .WORD_W(WORD_W), .IDX_W(MAIN_IW)) main_bank_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (commit_main),
        .widx  (main_idx),
        .wdata (wdata_q),
        .flat  (main_flat)
    );

    cfg_tok_bank #(.DEPTH(NREG_AUX), .WORD_W(WORD_W), .IDX_W(AUX_IW)) aux_bank_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (commit_aux),
        .widx  (addr_q[AUX_IW-1:0]),
        .wdata (wdata_q),
        .flat  (aux_regs)
    );

    cfg_tok_reply reply_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (rpl_start),
        .kind      (rpl_kind),
        .word      (rd_word),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_ctrl  (out_ctrl),
        .out_data  (out_data),
        .done      (rpl_done)
    );

endmodule

// File: rtl/cfg_tok_agent_chk.sv
module cfg_tok_agent_chk #(
    parameter int NREG_AUX = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   lock,
    input logic                   in_ready,
    input logic                   out_valid,
    input logic                   out_ready,
    input logic                   out_ctrl,
    input logic [7:0]             out_data,
    input logic [NREG_AUX*32-1:0] aux_regs
);

    // R1: while reset is held the agent is idle
    always @(posedge clk) begin
        if (!rst_n) begin
            a_rst_idle_r1: assert (!out_valid && in_ready)
                else $error("reset state wrong");
        end
    end

    p_hold_tok_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_ctrl) && $stable(out_data));

    p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    p_ctrl_codes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ctrl |-> (out_data == 8'd1 || out_data == 8'd3 || out_data == 8'd4));

    p_nak_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_ctrl && out_data == 8'd4
        |=> out_valid && out_ctrl && out_data == 8'd1);

    p_lock_aux_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(aux_regs));

endmodule

bind cfg_tok_agent cfg_tok_agent_chk #(.NREG_AUX(NREG_AUX)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock      (lock),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_ctrl  (out_ctrl),
    .out_data  (out_data),
    .aux_regs  (aux_regs)
);

// File: tb/cfg_tok_agent_tb_top.sv
module cfg_tok_agent_tb_top;

    localparam int NM = 8;
    localparam int NA = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lock = 1'b0;
    logic in_valid = 1'b0;
    logic in_ctrl = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic out_ready = 1'b0;
    logic in_ready, out_valid, out_ctrl;
    logic [7:0] out_data;
    logic [NA*32-1:0] aux_regs;

    always #5 clk = ~clk;

    cfg_tok_agent #(.NREG_MAIN(NM), .NREG_AUX(NA)) dut_i (
        .clk(clk), .rst_n(rst_n), .lock(lock),
        .in_valid(in_valid), .in_ready(in_ready), .in_ctrl(in_ctrl), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_ctrl(out_ctrl), .out_data(out_data),
        .aux_regs(aux_regs)
    );

    int n_chk = 0;
    int n_fail = 0;
    int r9_err = 0;
    int bp_pct = 0;
    logic [8:0] tx_q[$];
    logic [8:0] rx_q[$];
    logic [8:0] exp_q[$];
    logic [31:0] m_main[NM];
    logic [31:0] m_aux[NA];
    logic prev_hold = 1'b0;
    logic [8:0] prev_tok = '0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reply collector with random backpressure; R9 handshake observations
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_hold = 1'b0;
        end else begin
            if (out_valid && in_ready) r9_err++;
            if (prev_hold && !(out_valid && {out_ctrl, out_data} == prev_tok)) r9_err++;
            out_ready = ($urandom % 100) >= bp_pct;
            if (out_valid && out_ready) rx_q.push_back({out_ctrl, out_data});
            prev_hold = out_valid && !out_ready;
            prev_tok  = {out_ctrl, out_data};
        end
    end

    task automatic send_tok(input logic [8:0] t);
        @(negedge clk);
        in_valid = 1'b1;
        in_ctrl  = t[8];
        in_data  = t[7:0];
        while (!in_ready) @(negedge clk);
        @(posedge clk);
    endtask

    function automatic logic [63:0] aux_model();
        logic [63:0] v = '0;
        return v;
    endfunction

    task automatic do_req(input logic op_c, input logic [7:0] op, input logic [15:0] addr,
                          input logic [31:0] wd, input int mode, input int cut, input string tag);
        logic [7:0] f[9];
        bit known, ok;
        int nf, nsend, w;
        logic [63:0] act_p, exp_p;
        known = op_c && (op == 8'd192 || op == 8'd193 || op == 8'd36);
        nf = (known && op == 8'd193) ? 5 : 9;
        for (int i = 0; i < 3; i++) f[i] = 8'($urandom);
        f[3] = addr[15:8]; f[4] = addr[7:0];
        f[5] = wd[31:24]; f[6] = wd[23:16]; f[7] = wd[15:8]; f[8] = wd[7:0];
        nsend = (mode == 1) ? cut : nf;
        tx_q.delete(); exp_q.delete(); rx_q.delete();
        tx_q.push_back({op_c, op});
        for (int i = 0; i < nsend; i++) tx_q.push_back({1'b0, f[i]});
        if (mode == 2) tx_q.push_back(9'h05A);
        tx_q.push_back(9'h101);
        // expected reply from the requirements
        if (!known || mode != 0) begin
            exp_q.push_back(9'h104); exp_q.push_back(9'h101);
        end else if (op == 8'd192) begin
            if (addr < 16'(NM) && !lock) begin
                m_main[addr[2:0]] = wd;
                exp_q.push_back(9'h103);
            end else exp_q.push_back(9'h104);
            exp_q.push_back(9'h101);
        end else if (op == 8'd36) begin
            if (addr < 16'(NA) && !lock) begin
                m_aux[addr[1:0]] = wd;
                exp_q.push_back(9'h103);
            end else exp_q.push_back(9'h104);
            exp_q.push_back(9'h101);
        end else begin
            if (addr < 16'(NM)) begin
                exp_q.push_back(9'h103);
                for (int b = 3; b >= 0; b--) exp_q.push_back({1'b0, m_main[addr[2:0]][8*b +: 8]});
            end else exp_q.push_back(9'h104);
            exp_q.push_back(9'h101);
        end
        foreach (tx_q[i]) send_tok(tx_q[i]);
        @(negedge clk);
        in_valid = 1'b0;
        w = 0;
        while (!(rx_q.size() >= exp_q.size() && in_ready) && w < 3000) begin
            @(negedge clk);
            w++;
        end
        ok = (rx_q.size() == exp_q.size());
        act_p = '0; exp_p = '0;
        foreach (rx_q[i]) begin
            act_p = {act_p[54:0], rx_q[i]};
            if (i < exp_q.size() && rx_q[i] != exp_q[i]) ok = 0;
        end
        foreach (exp_q[i]) exp_p = {exp_p[54:0], exp_q[i]};
        chk(ok, tag, act_p, exp_p);
    endtask

    task automatic chk_aux(input string tag);
        logic [NA*32-1:0] e;
        for (int k = 0; k < NA; k++) e[k*32 +: 32] = m_aux[k];
        chk(aux_regs == e, tag, 64'(aux_regs), 64'(e));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < NM; k++) m_main[k] = '0;
        for (int k = 0; k < NA; k++) m_aux[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 idle after reset", 64'({in_ready, out_valid}), 64'h2);
        chk_aux("R1 aux bank cleared");
        do_req(1'b1, 8'd193, 16'd2, 32'h0, 0, 0, "R1 main reg reads zero");
        // R2 / R3 write then read back, MSB first
        do_req(1'b1, 8'd192, 16'd5, 32'hA1B2C3D4, 0, 0, "R2 main write ack");
        do_req(1'b1, 8'd193, 16'd5, 32'h0, 0, 0, "R3 read back bytes");
        do_req(1'b1, 8'd192, 16'd7, 32'h0102FEFF, 0, 0, "R2 write top register");
        do_req(1'b1, 8'd193, 16'd7, 32'h0, 0, 0, "R3 read top register");
        // R4 aux bank
        do_req(1'b1, 8'd36, 16'd3, 32'h11223344, 0, 0, "R4 aux write ack");
        chk_aux("R4 aux slot 3 visible");
        // R5 lock
        lock = 1'b1;
        do_req(1'b1, 8'd192, 16'd5, 32'hDEADBEEF, 0, 0, "R5 locked main write nak");
        do_req(1'b1, 8'd36, 16'd1, 32'hCAFEF00D, 0, 0, "R5 locked aux write nak");
        chk_aux("R5 aux unchanged under lock");
        do_req(1'b1, 8'd193, 16'd5, 32'h0, 0, 0, "R5 read under lock unchanged");
        lock = 1'b0;
        // R6 unmapped
        do_req(1'b1, 8'd192, 16'd8, 32'h12345678, 0, 0, "R6 main addr 8 nak");
        do_req(1'b1, 8'd193, 16'h0100, 32'h0, 0, 0, "R6 high address byte nak");
        do_req(1'b1, 8'd36, 16'd4, 32'h12345678, 0, 0, "R6 aux addr 4 nak");
        chk_aux("R6 aux unchanged");
        // R7 unknown opcodes
        do_req(1'b1, 8'h55, 16'd1, 32'h1, 0, 0, "R7 unknown control opcode");
        do_req(1'b0, 8'd192, 16'd1, 32'h1, 0, 0, "R7 data token as opcode");
        do_req(1'b1, 8'd193, 16'd5, 32'h0, 0, 0, "R7 normal read after discard");
        // R8 truncated and overlong
        do_req(1'b1, 8'd192, 16'd5, 32'h55555555, 1, 2, "R8 truncated in return id");
        do_req(1'b1, 8'd192, 16'd5, 32'h66666666, 1, 7, "R8 truncated in data");
        do_req(1'b1, 8'd193, 16'd5, 32'h0, 2, 0, "R8 overlong read");
        do_req(1'b1, 8'd193, 16'd5, 32'h0, 0, 0, "R8 register unchanged");
        // R9 heavy backpressure
        bp_pct = 75;
        do_req(1'b1, 8'd193, 16'd7, 32'h0, 0, 0, "R9 read under backpressure");
        // random mix
        for (int n = 0; n < 300; n++) begin
            int sel, mode, cut;
            logic oc;
            logic [7:0] op;
            bp_pct = $urandom % 60;
            lock = ($urandom % 5) == 0;
            sel = $urandom % 10;
            oc = 1'b1;
            case (sel)
                0, 1, 2: op = 8'd192;
                3, 4, 5: op = 8'd193;
                6, 7:    op = 8'd36;
                8:       op = 8'hC2;
                default: begin op = 8'd193; oc = 1'b0; end
            endcase
            mode = ($urandom % 8 == 0) ? 1 + ($urandom % 2) : 0;
            cut = (op == 8'd193) ? $urandom % 5 : $urandom % 9;
            do_req(oc, op, 16'($urandom % 11), $urandom, mode, cut, "random mix");
        end
        lock = 1'b0;
        chk_aux("R4 aux after random mix");
        chk(r9_err == 0, "R9 handshake hold and exclusion", 64'(r9_err), 64'd0);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule